// File: doc/BRIEF.md
# SIMD Byte-Lane Cluster with Run-Time Lane Ganging

This block is a compute cluster of four 8-bit cells that all obey one control word per cycle. A short instruction identifier arrives on a valid/ready stream. The cluster expands it into a full control word through a small local table that the host writes. That word names the operation, the lane width, the operand sources, two data-memory addresses, a shift amount and a multiplier constant. Each cell takes its operand bytes through its own pair of input selectors. The sources are two local data banks, which can be read at the same time, a network input and a far-row input. The result goes out on a valid/ready stream one cycle after the identifier is accepted.

A width mode gangs the cells at run time. Each cell can be its own 8-bit lane. Cells 0-1 and 2-3 can pair into 16-bit lanes. All four cells can also form one 32-bit lane. Carries and borrows ripple from byte to byte inside a lane and stop at lane edges. Absolute difference and compare use the full width of each lane. Shifts and multiplies also stay inside their lanes.

Back-pressure rule: an identifier is accepted on a clock edge where `id_valid` and `id_ready` are both high. `id_ready` is high when the result register is empty or is being drained in the same cycle. A result held with `out_ready` low keeps `out_data` unchanged. The table and bank write ports are plain control pins. A write in the same cycle as an accepted identifier is not visible to that identifier.

Top module: `simd_lane_cluster`

## Requirements
- R1: While reset is held and after it is released, `out_valid` is 0 and `id_ready` is 1.
- R2: `id_ready` equals (not `out_valid`) or `out_ready`. An accepted identifier gives `out_valid` high on the next cycle. While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` stay unchanged. With no accept and a drained output, `out_valid` falls.
- R3: The 4-bit identifier selects one of 16 table entries. An entry written through `tbl_we`/`tbl_idx`/`tbl_word` controls every identifier accepted in a later cycle. Control word fields, given as bit ranges: op [3:0], mode [5:4], source A [7:6], source B [9:8], address A [13:10], address B [17:14], shift amount [22:18], constant [30:23].
- R4: Source codes select the operand: 0 = bank 0 at the address, 1 = bank 1 at the address, 2 = `net_in`, 3 = `far_in`. Operand A and operand B may both read the banks in the same cycle.
- R5: Mode codes: 0 gives four 8-bit lanes, 1 gives two 16-bit lanes (bytes 1:0 and 3:2), and 2 or 3 gives one 32-bit lane. Op 0 (add) and op 1 (A minus B) are taken modulo the lane size, with carries and borrows chained inside a lane and blocked at lane edges.
- R6: Op 5 returns |A - B| for each lane, computed over the full lane width.
- R7: Op 6 returns 1 in the lowest bit of each lane where A > B (unsigned) and 0 elsewhere, so all other bits of the lane are 0.
- R8: Op 7 returns the low lane-width bits of A times B for each lane. Op 8 does the same with the 8-bit constant field in place of B.
- R9: Op 9 (shift left) and op 10 (logical shift right) shift each lane of A by the shift amount modulo the lane width. Bits never cross into a neighbouring lane.
- R10: Op 2, 3 and 4 give bitwise AND, OR and XOR of A and B. Op 11 passes A through. Op codes 12 to 15 give a zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_valid | input | 1 | Instruction identifier valid |
| id_ready | output | 1 | Cluster can accept an identifier |
| id_code | input | 4 | Instruction identifier (table index) |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | 32 | Registered result, byte i from cell i |
| tbl_we | input | 1 | Instruction table write enable |
| tbl_idx | input | 4 | Instruction table write index |
| tbl_word | input | 31 | Control word to store |
| mem_we | input | 1 | Data bank write enable |
| mem_bank | input | 1 | Data bank select for the write |
| mem_addr | input | 4 | Data bank write address |
| mem_word | input | 32 | Data bank write data |
| net_in | input | 32 | Network operand input |
| far_in | input | 32 | Far-row operand input |

## Verification
The bench builds the cluster with its default sizes: four 8-bit cells, a 16-entry table and two 16-word banks. With these sizes, random stimulus reaches every identifier, every bank address, all three lane widths and all 32 shift amounts within a few hundred cycles. Directed cases drive carries and borrows across byte and half-word edges and check compare and absolute difference on operands that differ only in their upper or lower lanes. A random phase mixes table and bank rewrites with stalls on the output.

// File: rtl/simd_pkg.sv
package simd_pkg;
  localparam int LANE_W  = 8;
  localparam int NCELL   = 4;
  localparam int DATA_W  = LANE_W * NCELL;
  localparam int ID_W    = 4;
  localparam int TBL_N   = 1 << ID_W;
  localparam int MADDR_W = 4;
  localparam int MEM_N   = 1 << MADDR_W;
  localparam int SH_W    = $clog2(DATA_W);
  localparam int NSIZE   = 3;   // 8, 16, 32-bit lane sizes

  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_SUB = 4'd1, OP_AND = 4'd2, OP_OR = 4'd3,
    OP_XOR = 4'd4, OP_ABSD = 4'd5, OP_CMPGT = 4'd6, OP_MUL = 4'd7,
    OP_MULK = 4'd8, OP_SHL = 4'd9, OP_SHR = 4'd10, OP_PASS = 4'd11
  } op_e;

  typedef enum logic [1:0] {
    SRC_BANK0 = 2'd0, SRC_BANK1 = 2'd1, SRC_NET = 2'd2, SRC_FAR = 2'd3
  } src_e;

  typedef struct packed {
    logic [LANE_W-1:0]  kconst;
    logic [SH_W-1:0]    shamt;
    logic [MADDR_W-1:0] addr_b;
    logic [MADDR_W-1:0] addr_a;
    src_e               src_b;
    src_e               src_a;
    logic [1:0]         mode;
    op_e                op;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
endpackage

// File: rtl/simd_instr_table.sv
module simd_instr_table #(
  parameter int W     = 31,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] entry [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int j = 0; j < DEPTH; j++) entry[j] <= '0;
    end else if (we) begin
      entry[waddr] <= wdata;
    end
  end

  assign rdata = entry[raddr];
endmodule

// File: rtl/simd_data_banks.sv
module simd_data_banks #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  logic               wbank,
  input  logic [AW-1:0]      waddr,
  input  logic [W-1:0]       wdata,
  input  logic [AW-1:0]      raddr_a,
  input  logic [AW-1:0]      raddr_b,
  output logic [1:0][W-1:0]  qa,
  output logic [1:0][W-1:0]  qb
);
  for (genvar k = 0; k < 2; k++) begin : g_bank
    logic [W-1:0] word [DEPTH];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        for (int j = 0; j < DEPTH; j++) word[j] <= '0;
      end else if (we && (wbank == 1'(k))) begin
        word[waddr] <= wdata;
      end
    end

    assign qa[k] = word[raddr_a];
    assign qb[k] = word[raddr_b];
  end
endmodule

// File: rtl/simd_byte_cell.sv
module simd_byte_cell #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         bin_ab,
  input  logic         bin_ba,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic [W-1:0] d_ab,
  output logic         bout_ab,
  output logic [W-1:0] d_ba,
  output logic         bout_ba
);
  logic [W:0] s_ext, ab_ext, ba_ext;

  assign s_ext  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
  assign ab_ext = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, bin_ab};
  assign ba_ext = {1'b0, b} - {1'b0, a} - {{W{1'b0}}, bin_ba};

  assign sum     = s_ext[W-1:0];
  assign cout    = s_ext[W];
  assign d_ab    = ab_ext[W-1:0];
  assign bout_ab = ab_ext[W];
  assign d_ba    = ba_ext[W-1:0];
  assign bout_ba = ba_ext[W];
endmodule

// File: rtl/simd_wide_unit.sv
module simd_wide_unit #(
  parameter int LANE_W = 8,
  parameter int DATA_W = 32,
  parameter int NSIZE  = 3,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [1:0]        mode,
  input  logic [SH_W-1:0]   shamt,
  input  logic [LANE_W-1:0] kconst,
  output logic [DATA_W-1:0] mul_r,
  output logic [DATA_W-1:0] mulk_r,
  output logic [DATA_W-1:0] shl_r,
  output logic [DATA_W-1:0] shr_r
);
  wire [DATA_W-1:0] mul_v  [NSIZE];
  wire [DATA_W-1:0] mulk_v [NSIZE];
  wire [DATA_W-1:0] shl_v  [NSIZE];
  wire [DATA_W-1:0] shr_v  [NSIZE];

  // One copy of each lane-local unit per lane size; bits never leave a lane.
  for (genvar g = 0; g < NSIZE; g++) begin : g_size
    localparam int W  = LANE_W << g;
    localparam int NL = DATA_W / W;
    localparam int SW = $clog2(W);
    for (genvar l = 0; l < NL; l++) begin : g_lane
      wire [W-1:0] la = a[l*W +: W];
      wire [W-1:0] lb = b[l*W +: W];
      wire [W-1:0] lk = W'(kconst);
      assign mul_v[g][l*W +: W]  = la * lb;
      assign mulk_v[g][l*W +: W] = la * lk;
      assign shl_v[g][l*W +: W]  = la << shamt[SW-1:0];
      assign shr_v[g][l*W +: W]  = la >> shamt[SW-1:0];
    end
  end

  logic [1:0] sz;
  assign sz = (mode > 2'(NSIZE-1)) ? 2'(NSIZE-1) : mode;

  assign mul_r  = mul_v[sz];
  assign mulk_r = mulk_v[sz];
  assign shl_r  = shl_v[sz];
  assign shr_r  = shr_v[sz];
endmodule

// File: rtl/simd_lane_cluster.sv
module simd_lane_cluster
  import simd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               id_valid,
  output logic               id_ready,
  input  logic [ID_W-1:0]    id_code,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DATA_W-1:0]  out_data,
  input  logic               tbl_we,
  input  logic [ID_W-1:0]    tbl_idx,
  input  logic [CTL_W-1:0]   tbl_word,
  input  logic               mem_we,
  input  logic               mem_bank,
  input  logic [MADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0]  mem_word,
  input  logic [DATA_W-1:0]  net_in,
  input  logic [DATA_W-1:0]  far_in
);
  ctl_t                   ctl;
  logic [CTL_W-1:0]       ctl_raw;
  logic [1:0][DATA_W-1:0] qa, qb;
  logic                   accept;

  // R3: identifier expands through the local table
  simd_instr_table #(.W(CTL_W), .DEPTH(TBL_N)) u_tbl (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .waddr(tbl_idx), .wdata(tbl_word),
    .raddr(id_code), .rdata(ctl_raw)
  );
  assign ctl = ctl_t'(ctl_raw);

  // R4: two banks, both readable by operand A and operand B each cycle
  simd_data_banks #(.W(DATA_W), .DEPTH(MEM_N)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(mem_we), .wbank(mem_bank), .waddr(mem_addr),
    .wdata(mem_word), .raddr_a(ctl.addr_a), .raddr_b(ctl.addr_b), .qa(qa), .qb(qb)
  );

  wire               wide16 = (ctl.mode == 2'd1);
  wire               wide32 = ctl.mode[1];
  wire [DATA_W-1:0]  opnd_a, opnd_b, res;
  wire [NCELL-1:0]   link, c_out, b_ab, b_ba, lane_lt, lane_gt;
  wire [NCELL-1:0][LANE_W-1:0] sum_b, dab_b, dba_b;
  logic [DATA_W-1:0] mul_r, mulk_r, shl_r, shr_r;

  for (genvar i = 0; i < NCELL; i++) begin : g_cell
    logic [LANE_W-1:0] ca, cb, r;
    wire               cin, bin_ab, bin_ba;

    always_comb begin
      unique case (ctl.src_a)
        SRC_BANK0: ca = qa[0][i*LANE_W +: LANE_W];
        SRC_BANK1: ca = qa[1][i*LANE_W +: LANE_W];
        SRC_NET:   ca = net_in[i*LANE_W +: LANE_W];
        default:   ca = far_in[i*LANE_W +: LANE_W];
      endcase
      unique case (ctl.src_b)
        SRC_BANK0: cb = qb[0][i*LANE_W +: LANE_W];
        SRC_BANK1: cb = qb[1][i*LANE_W +: LANE_W];
        SRC_NET:   cb = net_in[i*LANE_W +: LANE_W];
        default:   cb = far_in[i*LANE_W +: LANE_W];
      endcase
    end
    assign opnd_a[i*LANE_W +: LANE_W] = ca;
    assign opnd_b[i*LANE_W +: LANE_W] = cb;

    // R5: cell i joins the lane below it when the mode gangs them
    assign link[i] = (i != 0) && (wide32 || (wide16 && (i % 2 == 1)));

    if (i == 0) begin : g_first
      assign cin    = 1'b0;
      assign bin_ab = 1'b0;
      assign bin_ba = 1'b0;
    end else begin : g_next
      assign cin    = link[i] & c_out[i-1];
      assign bin_ab = link[i] & b_ab[i-1];
      assign bin_ba = link[i] & b_ba[i-1];
    end

    simd_byte_cell #(.W(LANE_W)) u_cell (
      .a(ca), .b(cb), .cin(cin), .bin_ab(bin_ab), .bin_ba(bin_ba),
      .sum(sum_b[i]), .cout(c_out[i]), .d_ab(dab_b[i]), .bout_ab(b_ab[i]),
      .d_ba(dba_b[i]), .bout_ba(b_ba[i])
    );

    // R6/R7: the lane's top borrow is broadcast down to every cell in the lane
    if (i == NCELL - 1) begin : g_top
      assign lane_lt[i] = b_ab[i];
      assign lane_gt[i] = b_ba[i];
    end else begin : g_mid
      assign lane_lt[i] = link[i+1] ? lane_lt[i+1] : b_ab[i];
      assign lane_gt[i] = link[i+1] ? lane_gt[i+1] : b_ba[i];
    end

    always_comb begin
      case (ctl.op)
        OP_ADD:   r = sum_b[i];
        OP_SUB:   r = dab_b[i];
        OP_AND:   r = ca & cb;
        OP_OR:    r = ca | cb;
        OP_XOR:   r = ca ^ cb;
        OP_ABSD:  r = lane_lt[i] ? dba_b[i] : dab_b[i];
        OP_CMPGT: r = link[i] ? '0 : {{(LANE_W-1){1'b0}}, lane_gt[i]};
        OP_MUL:   r = mul_r[i*LANE_W +: LANE_W];
        OP_MULK:  r = mulk_r[i*LANE_W +: LANE_W];
        OP_SHL:   r = shl_r[i*LANE_W +: LANE_W];
        OP_SHR:   r = shr_r[i*LANE_W +: LANE_W];
        OP_PASS:  r = ca;
        default:  r = '0;   // R10: unassigned codes
      endcase
    end
    assign res[i*LANE_W +: LANE_W] = r;
  end

  simd_wide_unit #(.LANE_W(LANE_W), .DATA_W(DATA_W), .NSIZE(NSIZE)) u_wide (
    .a(opnd_a), .b(opnd_b), .mode(ctl.mode), .shamt(ctl.shamt), .kconst(ctl.kconst),
    .mul_r(mul_r), .mulk_r(mulk_r), .shl_r(shl_r), .shr_r(shr_r)
  );

  // R2: one-deep result register on a valid/ready stream
  assign id_ready = !out_valid || out_ready;
  assign accept   = id_valid && id_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_data  <= res;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/simd_lane_cluster_chk.sv
module simd_lane_cluster_chk
  import simd_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              id_valid,
  input logic              id_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic [3:0]        op,
  input logic [1:0]        mode
);
  wire acc = id_valid && id_ready;

  // R2
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R2
  accept_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  // R2
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && !acc) |=> !out_valid);

  // R2
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> id_ready);

  // R7
  cmp_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == 4'(OP_CMPGT) && mode[1]) |=> (out_data[DATA_W-1:1] == '0));

  // R7
  cmp_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && op == 4'(OP_CMPGT) && mode == 2'd1)
      |=> (out_data[31:17] == '0 && out_data[15:1] == '0));
endmodule

bind simd_lane_cluster simd_lane_cluster_chk u_chk (
  .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_ready(id_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .op(ctl.op), .mode(ctl.mode)
);

// File: tb/sim_simd_lane_cluster.sv
`timescale 1ns/1ps
module sim_simd_lane_cluster;
  logic        clk = 0, rst_n = 0;
  logic        id_valid = 0, id_ready, out_valid, out_ready = 1;
  logic [3:0]  id_code = 0, tbl_idx = 0, mem_addr = 0;
  logic [31:0] out_data, mem_word = 0, net_in = 0, far_in = 0;
  logic        tbl_we = 0, mem_we = 0, mem_bank = 0;
  logic [30:0] tbl_word = 0;

  int checks = 0, failures = 0;
  bit rand_on = 0, mon_on = 0;

  always #5 clk = ~clk;

  simd_lane_cluster u0 (
    .clk(clk), .rst_n(rst_n), .id_valid(id_valid), .id_ready(id_ready), .id_code(id_code),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_word(tbl_word),
    .mem_we(mem_we), .mem_bank(mem_bank), .mem_addr(mem_addr), .mem_word(mem_word),
    .net_in(net_in), .far_in(far_in)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference model
  logic [30:0] m_tbl [16];
  logic [31:0] m_mem [2][16];
  logic        m_valid = 0, m_acc = 0;
  logic [31:0] m_data = 0;
  string       m_tag = "R2";

  function automatic logic [31:0] pick(logic [1:0] s, logic [3:0] ad);
    case (s)
      2'd0: return m_mem[0][ad];
      2'd1: return m_mem[1][ad];
      2'd2: return net_in;
      default: return far_in;
    endcase
  endfunction

  function automatic logic [31:0] ref_exec(logic [30:0] cw, logic [31:0] a, logic [31:0] b);
    int op = int'(cw[3:0]);
    int md = int'(cw[5:4]);
    int sh = int'(cw[22:18]);
    longint unsigned k = longint'(cw[30:23]);
    int w = (md == 0) ? 8 : (md == 1) ? 16 : 32;
    longint unsigned mask = (64'd1 << w) - 1;
    logic [31:0] r = 0;
    for (int l = 0; l < 32 / w; l++) begin
      longint unsigned ua = (longint'(a) >> (l * w)) & mask;
      longint unsigned ub = (longint'(b) >> (l * w)) & mask;
      longint unsigned v = 0;
      case (op)
        0: v = ua + ub;
        1: v = ua - ub;
        2: v = ua & ub;
        3: v = ua | ub;
        4: v = ua ^ ub;
        5: v = (ua > ub) ? ua - ub : ub - ua;
        6: v = (ua > ub) ? 1 : 0;
        7: v = ua * ub;
        8: v = ua * k;
        9: v = ua << (sh % w);
        10: v = ua >> (sh % w);
        11: v = ua;
        default: v = 0;
      endcase
      r = r | (32'(v & mask) << (l * w));
    end
    return r;
  endfunction

  function automatic string tag_of(logic [30:0] cw);
    string t;
    case (int'(cw[3:0]))
      0, 1: t = "R5";
      5: t = "R6";
      6: t = "R7";
      7, 8: t = "R8";
      9, 10: t = "R9";
      default: t = "R10";
    endcase
    if (cw[7] || cw[9]) t = {t, "/R4"};
    return t;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 0; m_acc <= 0; m_data <= 0;
    end else begin
      bit acc;
      acc = id_valid && (!m_valid || out_ready);
      m_acc <= acc;
      if (acc) begin
        m_data  <= ref_exec(m_tbl[id_code], pick(m_tbl[id_code][7:6], m_tbl[id_code][13:10]),
                            pick(m_tbl[id_code][9:8], m_tbl[id_code][17:14]));
        m_tag   <= tag_of(m_tbl[id_code]);
        m_valid <= 1;
      end else if (out_ready) begin
        m_valid <= 0;
      end
      if (tbl_we) m_tbl[tbl_idx] <= tbl_word;
      if (mem_we) m_mem[mem_bank][mem_addr] <= mem_word;
    end
  end

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    #2;
    if (mon_on && rst_n) begin
      check("R2 out_valid", 32'(out_valid), 32'(m_valid));
      check("R2 id_ready", 32'(id_ready), 32'(!m_valid || out_ready));
      if (m_valid) check(m_tag, out_data, m_data);
    end
  end

  always @(negedge clk) begin
    net_in    <= $urandom;
    far_in    <= $urandom;
    out_ready <= rand_on ? 1'($urandom) : 1'b1;
  end

  function automatic logic [30:0] mk(int op, int md, int sa, int sb, int aa, int ab, int sh, int k);
    return {8'(k), 5'(sh), 4'(ab), 4'(aa), 2'(sb), 2'(sa), 2'(md), 4'(op)};
  endfunction

  task automatic wr_mem(bit bank, int ad, logic [31:0] d);
    @(negedge clk);
    mem_we = 1; mem_bank = bank; mem_addr = 4'(ad); mem_word = d;
    @(negedge clk);
    mem_we = 0;
  endtask

  task automatic issue(logic [3:0] id);
    @(negedge clk);
    id_valid = 1; id_code = id;
    do begin
      @(posedge clk); #1;
    end while (!m_acc);
    id_valid = 0;
  endtask

  task automatic run_direct(int idx, logic [30:0] cw, logic [31:0] exp, string tag);
    @(negedge clk);
    tbl_we = 1; tbl_idx = 4'(idx); tbl_word = cw;
    @(negedge clk);
    tbl_we = 0;
    issue(4'(idx));
    #3;
    check(tag, out_data, exp);
  endtask

  initial begin
    for (int j = 0; j < 16; j++) begin
      m_tbl[j] = 0; m_mem[0][j] = 0; m_mem[1][j] = 0;
    end
    repeat (4) @(negedge clk);
    #2;
    check("R1 out_valid in reset", 32'(out_valid), 0);
    check("R1 id_ready in reset", 32'(id_ready), 1);
    rst_n = 1;
    @(negedge clk); #2;
    check("R1 out_valid after reset", 32'(out_valid), 0);
    check("R1 id_ready after reset", 32'(id_ready), 1);
    mon_on = 1;

    wr_mem(0, 0, 32'hFFFF_FFFF); wr_mem(1, 0, 32'h0000_0001);
    wr_mem(0, 1, 32'h0001_0000); wr_mem(1, 1, 32'h0000_0001);
    wr_mem(0, 2, 32'h1234_5678); wr_mem(1, 2, 32'h1234_5679);
    wr_mem(0, 3, 32'h0100_00FF); wr_mem(1, 3, 32'h00FF_0100);
    wr_mem(0, 4, 32'h1003_FF02); wr_mem(1, 4, 32'h1005_FF80);

    // R5: carry chains stop at lane edges
    run_direct(0, mk(0, 0, 0, 1, 0, 0, 0, 0), 32'hFFFF_FF00, "R5 add 8-bit");
    run_direct(1, mk(0, 1, 0, 1, 0, 0, 0, 0), 32'hFFFF_0000, "R5 add 16-bit");
    run_direct(2, mk(0, 2, 0, 1, 0, 0, 0, 0), 32'h0000_0000, "R5 add 32-bit");
    run_direct(3, mk(1, 0, 0, 1, 1, 1, 0, 0), 32'h0001_00FF, "R5 sub 8-bit");
    run_direct(4, mk(1, 3, 0, 1, 1, 1, 0, 0), 32'h0000_FFFF, "R5 sub 32-bit mode 3");
    // R6
    run_direct(5, mk(5, 0, 0, 1, 3, 3, 0, 0), 32'h01FF_01FF, "R6 absdiff 8-bit");
    run_direct(6, mk(5, 1, 0, 1, 3, 3, 0, 0), 32'h0001_0001, "R6 absdiff 16-bit");
    run_direct(7, mk(5, 2, 0, 1, 3, 3, 0, 0), 32'h0000_FFFF, "R6 absdiff 32-bit");
    // R7
    run_direct(8, mk(6, 1, 0, 1, 3, 3, 0, 0), 32'h0001_0000, "R7 compare 16-bit");
    run_direct(9, mk(6, 0, 0, 1, 3, 3, 0, 0), 32'h0100_0001, "R7 compare 8-bit");
    // R8
    run_direct(10, mk(7, 0, 0, 1, 4, 4, 0, 0), 32'h000F_0100, "R8 multiply 8-bit");
    run_direct(11, mk(8, 1, 0, 1, 2, 2, 0, 3), 32'h369C_0368, "R8 constant multiply 16-bit");
    // R9
    run_direct(12, mk(9, 0, 0, 1, 0, 0, 9, 0), 32'hFEFE_FEFE, "R9 shl 8-bit");
    run_direct(13, mk(9, 2, 0, 1, 0, 0, 9, 0), 32'hFFFF_FE00, "R9 shl 32-bit");
    run_direct(14, mk(10, 1, 0, 1, 2, 2, 4, 0), 32'h0123_0567, "R9 shr 16-bit");
    // R10
    run_direct(15, mk(4, 0, 0, 1, 2, 2, 0, 0), 32'h0000_0001, "R10 xor");
    run_direct(15, mk(13, 2, 0, 1, 2, 2, 0, 0), 32'h0000_0000, "R10 unassigned op");
    // R3: rewriting an entry changes what its identifier does
    run_direct(0, mk(3, 0, 0, 1, 3, 3, 0, 0), 32'h01FF_01FF, "R3 table rewrite");
    issue(4'd2);
    #3;
    check("R3 untouched entry", out_data, 32'h0000_0000);

    // Random phase: stalls, table and bank rewrites, all sources
    rand_on = 1;
    for (int n = 0; n < 1500; n++) begin
      @(negedge clk);
      if (!(id_valid && !m_acc)) begin
        id_valid = ($urandom % 4) != 0;
        id_code  = 4'($urandom);
      end
      tbl_we   = ($urandom % 5) == 0;
      tbl_idx  = 4'($urandom);
      tbl_word = 31'($urandom);
      mem_we   = ($urandom % 6) == 0;
      mem_bank = 1'($urandom);
      mem_addr = 4'($urandom);
      mem_word = $urandom;
    end
    @(negedge clk);
    id_valid = 0; tbl_we = 0; mem_we = 0; rand_on = 0;
    repeat (6) @(negedge clk);
    mon_on = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule